// File: doc/BRIEF.md
# Streaming Variable-Length Instruction Decoder

This block reads a stream of instruction bytes for a small subset of a 32-bit CISC instruction set, one byte per cycle, under a valid/ready handshake. It skips leading prefix bytes and notes whether the operand-size override was among them. It then reads the primary opcode, an optional register-form ModR/M byte and an immediate whose width depends on the opcode and the prefixes. When the last byte of an instruction arrives it produces a single record. The record gives the operation class, two register fields, the operand size, the immediate widened to 32 bits, the total byte count and an error flag.

Three operations are decoded, all in their register-only forms: load of an immediate into a register, unsigned divide by a register, and three-operand signed multiply by an 8-bit immediate. Any byte the decoder cannot use ends the current instruction with an error record. The byte after it is treated as the first byte of a new instruction. An upstream fetch unit drives the byte input, and a downstream issue stage takes the records.

Top module: `insn_byte_decoder`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, raises `in_ready` and drops any partly received instruction, so the next accepted byte starts a fresh instruction.
- R2: The bytes F0h, F2h, F3h, 26h, 2Eh, 36h, 3Eh, 64h, 65h, 66h and 67h are prefixes when they come before the opcode. Each one adds one to `out_len`, which counts every byte of the instruction including prefixes.
- R3: `out_size16` is 1 exactly when 66h was one of the accepted prefixes of the instruction. No other prefix changes it.
- R4: Opcodes B8h–BFh give class 1, `out_dst` equal to opcode bits 2:0 and `out_src` 0. The immediate is assembled least-significant byte first. It is 4 bytes long (length = prefixes + 5), or 2 bytes long with bits 31:16 zero when 66h was seen (length = prefixes + 3).
- R5: F7h followed by a ModR/M byte with bits 7:6 = 11 and bits 5:3 = 6 gives class 2, `out_dst` = ModR/M bits 2:0, `out_src` = 6, immediate 0 and length prefixes + 2.
- R6: 6Bh followed by a ModR/M byte with bits 7:6 = 11 and one immediate byte gives class 3, `out_dst` = ModR/M bits 5:3 and `out_src` = ModR/M bits 2:0. The immediate byte is sign-extended to 32 bits, or to 16 bits with bits 31:16 zero when 66h was seen. Length is prefixes + 3.
- R7: Three cases produce an error record: an opcode outside the supported set, F7h with ModR/M bits 5:3 other than 6, and a ModR/M byte with bits 7:6 other than 11. The record has `out_err` = 1, class 0, both register fields 0, immediate 0, and the length of the bytes consumed up to and including the offending byte. Decoding restarts at the next byte.
- R8: A prefix that arrives when MAX_PFX (4) prefixes are already held ends the instruction with an error record of length MAX_PFX + 1.
- R9: `in_ready` is low exactly while a record is waiting. A waiting record holds all its fields stable until `out_ready` takes it. `out_valid` rises only in the cycle after a byte was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder takes the byte this cycle |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer takes the record |
| out_class | output | 2 | 0 none/error, 1 load-immediate, 2 divide, 3 multiply-immediate |
| out_dst | output | 3 | Destination register number |
| out_src | output | 3 | Source register or extension digit |
| out_size16 | output | 1 | 16-bit operand size selected |
| out_imm | output | 32 | Widened immediate |
| out_len | output | 4 | Total instruction length in bytes |
| out_err | output | 1 | Malformed or unsupported instruction |

## Verification
The hardest situation to reach is a record that waits while the upstream side keeps offering bytes: that cycle shows whether input back-pressure and record holding work together. The stimulus drives `out_ready` and `in_valid` from two independent cycle patterns, so records stall for one to several cycles in the middle of long byte streams. A second hard case is a reset that lands partway through a long immediate. The bench stops feeding after two bytes of a load-immediate, asserts reset, and then sends a complete divide, which has to decode as if nothing came before it.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_MOVI  = 2'd1,
    CLS_DIVR  = 2'd2,
    CLS_IMUL3 = 2'd3
  } op_class_t;

  typedef enum logic [1:0] {
    ST_LEAD  = 2'd0,
    ST_MODRM = 2'd1,
    ST_IMM   = 2'd2
  } dec_state_t;

  localparam logic [2:0] DIV_DIGIT = 3'd6;

  // drop one byte into a little-endian accumulator at byte slot idx
  function automatic logic [31:0] place_byte(input logic [31:0] acc,
                                             input logic [1:0]  idx,
                                             input logic [7:0]  b);
    logic [31:0] r;
    r = acc;
    r[8*idx +: 8] = b;
    return r;
  endfunction

  // widen a signed byte to 16 or 32 bits; above 16 bits stays zero in 16-bit mode
  function automatic logic [31:0] sext8(input logic [7:0] b, input logic is16);
    if (is16) return {16'h0000, {8{b[7]}}, b};
    return {{24{b[7]}}, b};
  endfunction

endpackage

// File: rtl/insn_prefix_match.sv
module insn_prefix_match (
  input  logic [7:0] byte_in,
  output logic       is_prefix,
  output logic       is_opsize
);
  always_comb begin
    unique case (byte_in)
      8'hF0, 8'hF2, 8'hF3,
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67: is_prefix = 1'b1;
      default:      is_prefix = 1'b0;
    endcase
    is_opsize = (byte_in == 8'h66);
  end
endmodule

// File: rtl/insn_opcode_map.sv
module insn_opcode_map (
  input  logic [7:0] byte_in,
  output logic       is_movi,
  output logic       is_div,
  output logic       is_imul,
  output logic [2:0] reg_lo
);
  assign is_movi = (byte_in[7:3] == 5'b10111);
  assign is_div  = (byte_in == 8'hF7);
  assign is_imul = (byte_in == 8'h6B);
  assign reg_lo  = byte_in[2:0];
endmodule

// File: rtl/insn_imm_gather.sv
module insn_imm_gather #(
  parameter int MAX_BYTES = 4,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic [7:0]       din,
  output logic [31:0]      acc,
  output logic [CNT_W-1:0] cnt
);
  import insn_dec_pkg::*;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= place_byte(acc, cnt[1:0], din);
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/insn_byte_decoder.sv
module insn_byte_decoder #(
  parameter int MAX_PFX = 4,
  localparam int LEN_W = $clog2(MAX_PFX + 6),
  localparam int PFX_W = $clog2(MAX_PFX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_class,
  output logic [2:0]       out_dst,
  output logic [2:0]       out_src,
  output logic             out_size16,
  output logic [31:0]      out_imm,
  output logic [LEN_W-1:0] out_len,
  output logic             out_err
);
  import insn_dec_pkg::*;

  localparam int IMM_MAX = 4;
  localparam int CNT_W   = $clog2(IMM_MAX + 1);

  dec_state_t       st_q, nxt_st;
  op_class_t        cls_q, nxt_cls, em_cls, out_cls_q;
  logic [LEN_W-1:0] len_q, nxt_len;
  logic [PFX_W-1:0] pfx_q, nxt_pfx;
  logic             sz16_q, nxt_sz16;
  logic [2:0]       dst_q, nxt_dst, src_q, nxt_src, em_dst, em_src;
  logic [CNT_W-1:0] need_q, nxt_need;
  logic [31:0]      em_imm;
  logic             em_err;

  // named events for the checks
  logic acc_fire, emit_now, rec_taken;
  assign in_ready  = !out_valid;
  assign acc_fire  = in_valid && in_ready;
  assign rec_taken = out_valid && out_ready;

  logic is_prefix, is_opsize, is_movi, is_div, is_imul;
  logic [2:0] reg_lo;
  logic [31:0] imm_acc;
  logic [CNT_W-1:0] imm_cnt;
  logic imm_take;

  insn_prefix_match u_pfx (.byte_in(in_byte), .is_prefix(is_prefix), .is_opsize(is_opsize));

  insn_opcode_map u_opc (.byte_in(in_byte), .is_movi(is_movi), .is_div(is_div),
                         .is_imul(is_imul), .reg_lo(reg_lo));

  assign imm_take = acc_fire && (st_q == ST_IMM);

  insn_imm_gather #(.MAX_BYTES(IMM_MAX)) u_imm (
    .clk(clk), .rst(rst), .clr(emit_now), .take(imm_take),
    .din(in_byte), .acc(imm_acc), .cnt(imm_cnt));

  wire [1:0] rm_mod = in_byte[7:6];
  wire [2:0] rm_mid = in_byte[5:3];
  wire [2:0] rm_low = in_byte[2:0];

  always_comb begin
    nxt_st = st_q; nxt_cls = cls_q; nxt_len = len_q; nxt_pfx = pfx_q;
    nxt_sz16 = sz16_q; nxt_dst = dst_q; nxt_src = src_q; nxt_need = need_q;
    emit_now = 1'b0; em_err = 1'b0;
    em_cls = cls_q; em_dst = dst_q; em_src = src_q; em_imm = '0;
    if (acc_fire) begin
      nxt_len = len_q + 1'b1;
      unique case (st_q)
        ST_LEAD: begin
          if (is_prefix) begin
            if (pfx_q == PFX_W'(MAX_PFX)) begin
              emit_now = 1'b1; em_err = 1'b1;
            end else begin
              nxt_pfx  = pfx_q + 1'b1;
              nxt_sz16 = sz16_q | is_opsize;
            end
          end else if (is_movi) begin
            nxt_cls  = CLS_MOVI; nxt_dst = reg_lo; nxt_src = 3'd0;
            nxt_need = sz16_q ? CNT_W'(2) : CNT_W'(4);
            nxt_st   = ST_IMM;
          end else if (is_div) begin
            nxt_cls = CLS_DIVR; nxt_st = ST_MODRM;
          end else if (is_imul) begin
            nxt_cls = CLS_IMUL3; nxt_st = ST_MODRM;
          end else begin
            emit_now = 1'b1; em_err = 1'b1;
          end
        end
        ST_MODRM: begin
          if (rm_mod != 2'b11) begin
            emit_now = 1'b1; em_err = 1'b1;
          end else if (cls_q == CLS_DIVR) begin
            emit_now = 1'b1;
            if (rm_mid == DIV_DIGIT) begin
              em_dst = rm_low; em_src = DIV_DIGIT;
            end else begin
              em_err = 1'b1;
            end
          end else begin
            nxt_dst = rm_mid; nxt_src = rm_low;
            nxt_need = CNT_W'(1); nxt_st = ST_IMM;
          end
        end
        default: begin
          if ((imm_cnt + 1'b1) == need_q) begin
            emit_now = 1'b1;
            em_imm = (cls_q == CLS_IMUL3) ? sext8(in_byte, sz16_q)
                                          : place_byte(imm_acc, imm_cnt[1:0], in_byte);
          end
        end
      endcase
      if (em_err) begin
        em_cls = CLS_NONE; em_dst = 3'd0; em_src = 3'd0; em_imm = '0;
      end
      if (emit_now) begin
        nxt_st = ST_LEAD; nxt_len = '0; nxt_pfx = '0; nxt_sz16 = 1'b0;
        nxt_cls = CLS_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_LEAD; cls_q <= CLS_NONE; len_q <= '0; pfx_q <= '0;
      sz16_q <= 1'b0; dst_q <= '0; src_q <= '0; need_q <= '0;
      out_valid <= 1'b0; out_cls_q <= CLS_NONE; out_dst <= '0; out_src <= '0;
      out_size16 <= 1'b0; out_imm <= '0; out_len <= '0; out_err <= 1'b0;
    end else begin
      st_q <= nxt_st; cls_q <= nxt_cls; len_q <= nxt_len; pfx_q <= nxt_pfx;
      sz16_q <= nxt_sz16; dst_q <= nxt_dst; src_q <= nxt_src; need_q <= nxt_need;
      if (emit_now) begin
        out_valid  <= 1'b1;
        out_cls_q  <= em_cls;
        out_dst    <= em_dst;
        out_src    <= em_src;
        out_size16 <= sz16_q;
        out_imm    <= em_imm;
        out_len    <= len_q + 1'b1;
        out_err    <= em_err;
      end else if (rec_taken) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign out_class = out_cls_q;

  // R9
  hold_rec_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_imm)
                                   && $stable(out_dst) && $stable(out_src) && $stable(out_err)));
  // R9
  rise_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(acc_fire));
  // R7
  err_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_class == 2'd0 && out_imm == 32'd0));
  // R6
  imul_range_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 2'd3) |->
      (out_size16 ? (out_imm[31:16] == 16'h0 && (out_imm[15:7] == '0 || &out_imm[15:7]))
                  : (out_imm[31:7] == '0 || &out_imm[31:7])));
  // R4
  movi_len_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_class == 2'd1) |->
      (out_size16 ? (out_len >= LEN_W'(4) && out_imm[31:16] == 16'h0) : out_len >= LEN_W'(5)));
  // R8
  pfx_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pfx_q <= PFX_W'(MAX_PFX));
endmodule

// File: tb/sim_insn_byte_decoder.sv
module sim_insn_byte_decoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic out_ready = 1'b0;
  logic in_ready, out_valid, out_size16, out_err;
  logic [1:0] out_class;
  logic [2:0] out_dst, out_src;
  logic [31:0] out_imm;
  logic [3:0] out_len;

  always #5 clk = ~clk;

  insn_byte_decoder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_class(out_class), .out_dst(out_dst),
    .out_src(out_src), .out_size16(out_size16), .out_imm(out_imm), .out_len(out_len),
    .out_err(out_err));

  typedef struct {
    int cls; int dst; int src; int s16; longint imm; int len; int err;
  } rec_t;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  byte unsigned byte_q[$];
  rec_t exp_q[$];

  // behavioural model state
  int m_phase = 0, m_len = 0, m_pfx = 0, m_s16 = 0, m_cls = 0;
  int m_dst = 0, m_src = 0, m_need = 0, m_got = 0;
  longint m_imm = 0;

  // stall tracking
  logic hold_pend = 1'b0;
  rec_t held;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic model_clear();
    m_phase = 0; m_len = 0; m_pfx = 0; m_s16 = 0; m_cls = 0;
    m_dst = 0; m_src = 0; m_need = 0; m_got = 0; m_imm = 0;
  endtask

  task automatic model_emit(input int c, input int d, input int s, input longint v, input int e);
    rec_t r;
    r.cls = c; r.dst = d; r.src = s; r.s16 = m_s16; r.imm = v; r.len = m_len; r.err = e;
    exp_q.push_back(r);
    model_clear();
  endtask

  task automatic model_feed(input byte unsigned b);
    int mo, mi, lo, sv;
    m_len++;
    if (m_phase == 0) begin
      if (b inside {8'hF0, 8'hF2, 8'hF3, 8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67}) begin
        if (m_pfx == 4) model_emit(0, 0, 0, 0, 1);
        else begin
          m_pfx++;
          if (b == 8'h66) m_s16 = 1;
        end
      end else if (b >= 8'hB8 && b <= 8'hBF) begin
        m_cls = 1; m_dst = b % 8; m_src = 0; m_need = m_s16 ? 2 : 4; m_got = 0; m_imm = 0;
        m_phase = 2;
      end else if (b == 8'hF7) begin
        m_cls = 2; m_phase = 1;
      end else if (b == 8'h6B) begin
        m_cls = 3; m_phase = 1;
      end else model_emit(0, 0, 0, 0, 1);
    end else if (m_phase == 1) begin
      mo = b / 64; mi = (b / 8) % 8; lo = b % 8;
      if (mo != 3) model_emit(0, 0, 0, 0, 1);
      else if (m_cls == 2) begin
        if (mi == 6) model_emit(2, lo, 6, 0, 0);
        else model_emit(0, 0, 0, 0, 1);
      end else begin
        m_dst = mi; m_src = lo; m_need = 1; m_got = 0; m_phase = 2;
      end
    end else begin
      if (m_cls == 3) begin
        sv = (b >= 128) ? int'(b) - 256 : int'(b);
        model_emit(3, m_dst, m_src, m_s16 ? (longint'(sv) & 64'hFFFF)
                                          : (longint'(sv) & 64'hFFFF_FFFF), 0);
      end else begin
        m_imm = m_imm + (longint'(b) << (8 * m_got));
        m_got++;
        if (m_got == m_need) model_emit(1, m_dst, 0, m_imm, 0);
      end
    end
  endtask

  task automatic compare_rec();
    rec_t e;
    string rq;
    if (exp_q.size() == 0) begin
      check(1'b0, "R9", "unexpected record", longint'(out_len), 0);
      return;
    end
    e = exp_q.pop_front();
    if (e.err != 0) rq = (e.len == 5 && e.cls == 0 && e.s16 >= 0 && e.len == 5) ? "R8" : "R7";
    else if (e.cls == 1) rq = "R4";
    else if (e.cls == 2) rq = "R5";
    else rq = "R6";
    check(out_class == e.cls[1:0], rq, "class", longint'(out_class), longint'(e.cls));
    check(out_dst == e.dst[2:0], rq, "dst", longint'(out_dst), longint'(e.dst));
    check(out_src == e.src[2:0], rq, "src", longint'(out_src), longint'(e.src));
    check(longint'(out_imm) == e.imm, rq, "imm", longint'(out_imm), e.imm);
    check(out_err == e.err[0], "R7", "err", longint'(out_err), longint'(e.err));
    check(out_size16 == e.s16[0], "R3", "size16", longint'(out_size16), longint'(e.s16));
    check(out_len == e.len[3:0], "R2", "len", longint'(out_len), longint'(e.len));
  endtask

  // single driver/monitor at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      in_valid <= 1'b0;
      out_ready <= 1'b0;
      hold_pend = 1'b0;
      model_clear();
    end else begin
      // R9: per-clock handshake relation and stall stability
      check(in_ready == !out_valid, "R9", "in_ready", longint'(in_ready), longint'(!out_valid));
      if (hold_pend) begin
        check(out_valid && out_len == held.len[3:0] && longint'(out_imm) == held.imm
              && out_dst == held.dst[2:0], "R9", "held record", longint'(out_len), longint'(held.len));
      end
      hold_pend = 1'b0;
      out_ready = ((cyc % 5) != 2) && ((cyc % 23) < 17);
      if (out_valid && out_ready) compare_rec();
      else if (out_valid) begin
        hold_pend = 1'b1;
        held.len = int'(out_len); held.imm = longint'(out_imm); held.dst = int'(out_dst);
      end
      if (byte_q.size() != 0 && (cyc % 7) != 3) begin
        in_valid = 1'b1;
        in_byte = byte_q[0];
      end else in_valid = 1'b0;
      if (in_valid && in_ready) model_feed(byte_q.pop_front());
    end
  end

  task automatic push(input byte unsigned b);
    byte_q.push_back(b);
  endtask

  task automatic drain();
    while (byte_q.size() != 0 || exp_q.size() != 0 || out_valid) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    check(out_valid == 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", longint'(in_ready), 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R4 load-immediate, 32-bit
    push(8'hB8); push(8'h01); push(8'h00); push(8'h00); push(8'h00);
    push(8'hBE); push(8'h78); push(8'h56); push(8'h34); push(8'h12);
    // R3 R4 16-bit load
    push(8'h66); push(8'hB9); push(8'h34); push(8'h12);
    // R2 several prefixes, 67h leaves size alone
    push(8'hF0); push(8'h2E); push(8'h67); push(8'hBA);
    push(8'hEF); push(8'hBE); push(8'hAD); push(8'hDE);
    // R5 divide
    push(8'hF7); push(8'hF1);
    push(8'h66); push(8'hF7); push(8'hF6);
    // R7 wrong digit, then memory mode
    push(8'hF7); push(8'hD9);
    push(8'hF7); push(8'h31);
    // R6 multiply
    push(8'h6B); push(8'hC9); push(8'h0C);
    push(8'h6B); push(8'hD0); push(8'hF4);
    push(8'h66); push(8'h6B); push(8'hC3); push(8'h80);
    // R7 unsupported opcode
    push(8'h90);
    // R8 five prefixes
    push(8'hF3); push(8'hF2); push(8'h64); push(8'h65); push(8'h26);
    push(8'h36); push(8'h3E); push(8'h66); push(8'hB8); push(8'hFF); push(8'hFF);
    push(8'h6B); push(8'h08);
    for (int r = 0; r < 8; r++) begin
      push(8'hB8 + 8'(r));
      for (int k = 0; k < 4; k++) push(8'(r * 16 + k + 1));
    end
    drain();
    // R1 reset in the middle of an immediate
    push(8'hB8); push(8'h01);
    drain();
    do_reset();
    push(8'hF7); push(8'hF3);
    drain();
    check(exp_q.size() == 0, "R1", "pending records", longint'(exp_q.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule